// File: doc/BRIEF.md
# Two-Bank SDRAM Row State Tracker

This block watches the decoded command stream that a memory controller sends to a two-bank synchronous DRAM. From that stream it keeps, for each of the two banks, whether the bank is open and which row it holds. It also tracks which bank, if any, is currently running a burst. The controller reads the per-bank open flags and open-row registers to decide whether the next access is a row hit, which it can issue directly, or a row miss, which needs a precharge and then an activate.

Every read or write is checked against the state of its target bank. An access to a closed bank is illegal, and so is an activate to a bank that is already open. Either one raises a one-clock error pulse and leaves all tracked state as it was. The only legal way to change rows inside a bank is a precharge followed by an activate. Column commands may be issued on every clock, to one bank or alternating between both open banks, with no gap between them.

All outputs are registered. A command sampled at a rising clock edge is visible on the outputs immediately after that same edge.

Top module: `rowtrk_top`

## Requirements
- R1: While reset (rstN low) is asserted, and after it is released, both banks read closed, no burst is active and errPulse is low.
- R2: An activate (csN=0, rasN=0, casN=1, weN=1) to a closed bank opens that bank and stores addr as its open row. Bank 0 (bankAddr=0) is reported on openRowA and bank 1 on openRowB.
- R3: A read (csN=0, rasN=1, casN=0, weN=1) or write (csN=0, rasN=1, casN=0, weN=0) to an open bank raises no error and leaves the row unchanged. It makes that bank the bursting bank (burstOn=1, burstBank=bankAddr). This holds on every clock, whether the accesses go to the same bank or alternate between the banks.
- R4: A read or write to a closed bank pulses errPulse for exactly that cycle. It leaves the bank flags, the rows and the burst state unchanged.
- R5: An activate to an already open bank pulses errPulse and leaves that bank open with its previous row.
- R6: A precharge (csN=0, rasN=0, casN=1, weN=0) with addr[10]=0 closes only the bank selected by bankAddr. A precharge to a closed bank is legal and raises no error.
- R7: A precharge with addr[10]=1 closes both banks and ends any burst, whatever bankAddr is.
- R8: A single-bank precharge ends the burst when it targets the bursting bank. It leaves a burst on the other bank running.
- R9: A burst stop (csN=0, rasN=1, casN=1, weN=0) ends the burst and leaves both banks and rows unchanged.
- R10: A no-op (csN=0 with rasN, casN, weN all high), a deselect (csN=1), and the codes with rasN and casN both low change no state and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| bankAddr | input | 1 | Target bank of the command |
| addr | input | ROW_W | Row address on activate; bit 10 selects all banks on precharge |
| bankOpen | output | 2 | Open flag per bank, bit 0 = bank A |
| openRowA | output | ROW_W | Open row of bank A, valid while bankOpen[0] is set |
| openRowB | output | ROW_W | Open row of bank B, valid while bankOpen[1] is set |
| burstOn | output | 1 | A read or write burst is in progress |
| burstBank | output | 1 | Bank of the running burst, valid while burstOn is set |
| errPulse | output | 1 | One-cycle flag for an illegal command |

## Verification
The bound checker checks on every cycle how each command class is answered one edge later. A legal activate must load the row, and an illegal access or activate must pulse the error and freeze state. A full or matching precharge, and a burst stop, must end the burst. Quiet codes must leave everything alone. Longer histories can only be shown by the bench's scenarios: a row change done through precharge and then activate, back-to-back ping-pong accesses across both banks, and a precharge of the non-bursting bank that leaves the burst running. The bench's scenarios compare every output against an independent model after each command of a long seeded random stream.

// File: rtl/rowtrk_pkg.sv
package rowtrk_pkg;
  localparam int BANK_CNT = 2;

  typedef enum logic [2:0] {
    CmdNop, CmdAct, CmdRead, CmdWrite, CmdPre, CmdStop, CmdOther
  } cmd_e;

  typedef struct packed {
    logic                openEn;
    logic [BANK_CNT-1:0] closeEn;
    logic                burstStart;
    logic                burstEnd;
    logic                bank;
    logic                errSet;
  } strobe_t;
endpackage

// File: rtl/rowtrk_ctrl.sv
module rowtrk_ctrl
  import rowtrk_pkg::*;
(
  input  logic                csN,
  input  logic                rasN,
  input  logic                casN,
  input  logic                weN,
  input  logic                bankAddr,
  input  logic                allBanks,
  input  logic [BANK_CNT-1:0] bankOpen,
  input  logic                burstOn,
  input  logic                burstBank,
  output strobe_t             stb
);
  cmd_e cmd;

  // command decode from the strobe pins
  always_comb begin
    cmd = CmdOther;
    if (csN) begin
      cmd = CmdNop;
    end else begin
      case ({rasN, casN, weN})
        3'b111:  cmd = CmdNop;
        3'b011:  cmd = CmdAct;
        3'b101:  cmd = CmdRead;
        3'b100:  cmd = CmdWrite;
        3'b010:  cmd = CmdPre;
        3'b110:  cmd = CmdStop;
        default: cmd = CmdOther;
      endcase
    end
  end

  // legality check and strobe generation
  always_comb begin
    stb      = '0;
    stb.bank = bankAddr;
    case (cmd)
      CmdAct: begin
        if (bankOpen[bankAddr]) stb.errSet = 1'b1;
        else                    stb.openEn = 1'b1;
      end
      CmdRead, CmdWrite: begin
        if (bankOpen[bankAddr]) stb.burstStart = 1'b1;
        else                    stb.errSet     = 1'b1;
      end
      CmdPre: begin
        if (allBanks) begin
          stb.closeEn  = '1;
          stb.burstEnd = 1'b1;
        end else begin
          stb.closeEn[bankAddr] = 1'b1;
          stb.burstEnd = burstOn && (burstBank == bankAddr);
        end
      end
      CmdStop: stb.burstEnd = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/rowtrk_dp.sv
module rowtrk_dp
  import rowtrk_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  strobe_t                        stb,
  input  logic [ROW_W-1:0]               rowIn,
  output logic [BANK_CNT-1:0]            bankOpen,
  output logic [BANK_CNT-1:0][ROW_W-1:0] openRow,
  output logic                           burstOn,
  output logic                           burstBank,
  output logic                           errPulse
);
  for (genvar g = 0; g < BANK_CNT; g++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        bankOpen[g] <= 1'b0;
        openRow[g]  <= '0;
      end else if (stb.openEn && (stb.bank == 1'(g))) begin
        bankOpen[g] <= 1'b1;
        openRow[g]  <= rowIn;
      end else if (stb.closeEn[g]) begin
        bankOpen[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstOn   <= 1'b0;
      burstBank <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      errPulse <= stb.errSet;
      if (stb.burstStart) begin
        burstOn   <= 1'b1;
        burstBank <= stb.bank;
      end else if (stb.burstEnd) begin
        burstOn <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rowtrk_top.sv
module rowtrk_top
  import rowtrk_pkg::*;
#(
  parameter int ROW_W = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             rasN,
  input  logic             casN,
  input  logic             weN,
  input  logic             bankAddr,
  input  logic [ROW_W-1:0] addr,
  output logic [1:0]       bankOpen,
  output logic [ROW_W-1:0] openRowA,
  output logic [ROW_W-1:0] openRowB,
  output logic             burstOn,
  output logic             burstBank,
  output logic             errPulse
);
  localparam int ALL_BIT = 10;

  strobe_t                        stb;
  logic [BANK_CNT-1:0][ROW_W-1:0] openRow;

  rowtrk_ctrl uCtrl (
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .bankAddr (bankAddr),
    .allBanks (addr[ALL_BIT]),
    .bankOpen (bankOpen),
    .burstOn  (burstOn),
    .burstBank(burstBank),
    .stb      (stb)
  );

  rowtrk_dp #(.ROW_W(ROW_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rowIn    (addr),
    .bankOpen (bankOpen),
    .openRow  (openRow),
    .burstOn  (burstOn),
    .burstBank(burstBank),
    .errPulse (errPulse)
  );

  assign openRowA = openRow[0];
  assign openRowB = openRow[1];
endmodule

// File: rtl/rowtrk_chk.sv
module rowtrk_chk #(
  parameter int ROW_W = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             rasN,
  input logic             casN,
  input logic             weN,
  input logic             bankAddr,
  input logic [ROW_W-1:0] addr,
  input logic [1:0]       bankOpen,
  input logic [ROW_W-1:0] openRowA,
  input logic [ROW_W-1:0] openRowB,
  input logic             burstOn,
  input logic             burstBank,
  input logic             errPulse
);
  logic isAct, isAcc, isPre, isStop, isQuiet;
  assign isAct   = !csN && !rasN &&  casN &&  weN;
  assign isAcc   = !csN &&  rasN && !casN;
  assign isPre   = !csN && !rasN &&  casN && !weN;
  assign isStop  = !csN &&  rasN &&  casN && !weN;
  assign isQuiet = csN || (rasN && casN && weN) || (!rasN && !casN);

  assert_act_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    isAct && !bankOpen[bankAddr] |=> bankOpen[$past(bankAddr)] && !errPulse &&
      (($past(bankAddr) ? openRowB : openRowA) == $past(addr)));

  assert_access_open_R3: assert property (@(posedge clk) disable iff (!rstN)
    isAcc && bankOpen[bankAddr] |=> !errPulse && burstOn && (burstBank == $past(bankAddr)));

  assert_access_closed_R4: assert property (@(posedge clk) disable iff (!rstN)
    isAcc && !bankOpen[bankAddr] |=> errPulse && $stable(bankOpen) && $stable(burstOn));

  assert_act_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    isAct && bankOpen[bankAddr] |=> errPulse && $stable(bankOpen) &&
      $stable(openRowA) && $stable(openRowB));

  assert_pre_all_R7: assert property (@(posedge clk) disable iff (!rstN)
    isPre && addr[10] |=> (bankOpen == 2'b00) && !burstOn && !errPulse);

  assert_pre_burst_R8: assert property (@(posedge clk) disable iff (!rstN)
    isPre && !addr[10] && burstOn && (burstBank == bankAddr) |=>
      !burstOn && !bankOpen[$past(bankAddr)]);

  assert_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    isStop |=> !burstOn && $stable(bankOpen) && !errPulse);

  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    isQuiet |=> !errPulse && $stable(bankOpen) && $stable(burstOn));
endmodule

bind rowtrk_top rowtrk_chk #(.ROW_W(ROW_W)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
  .bankAddr(bankAddr), .addr(addr), .bankOpen(bankOpen), .openRowA(openRowA),
  .openRowB(openRowB), .burstOn(burstOn), .burstBank(burstBank), .errPulse(errPulse)
);

// File: tb/sim_rowtrk_top.sv
`timescale 1ns/1ps
module sim_rowtrk_top;
  localparam int ROW_W = 11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, bankAddr = 1'b0;
  logic [ROW_W-1:0] addr = '0;
  logic [1:0] bankOpen;
  logic [ROW_W-1:0] openRowA, openRowB;
  logic burstOn, burstBank, errPulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [1:0] mOpen;
  logic [ROW_W-1:0] mRow [2];
  logic mBurst, mBank, mErr;

  always #2.5 clk = ~clk;

  rowtrk_top #(.ROW_W(ROW_W)) u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .bankAddr(bankAddr), .addr(addr), .bankOpen(bankOpen), .openRowA(openRowA),
    .openRowB(openRowB), .burstOn(burstOn), .burstBank(burstBank), .errPulse(errPulse)
  );

  function automatic string tagFor(logic c, logic r, logic a, logic w, logic [ROW_W-1:0] ad);
    if (c) return "R10";
    case ({r, a, w})
      3'b011: return "R2/R5";
      3'b101, 3'b100: return "R3/R4";
      3'b010: return ad[10] ? "R7" : "R6/R8";
      3'b110: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic modelStep(logic c, logic r, logic a, logic w, logic b, logic [ROW_W-1:0] ad);
    mErr = 1'b0;
    if (!c) begin
      case ({r, a, w})
        3'b011: if (mOpen[b]) mErr = 1'b1; else begin mOpen[b] = 1'b1; mRow[b] = ad; end
        3'b101, 3'b100: if (!mOpen[b]) mErr = 1'b1; else begin mBurst = 1'b1; mBank = b; end
        3'b010: begin
          if (ad[10]) begin mOpen = 2'b00; mBurst = 1'b0; end
          else begin
            mOpen[b] = 1'b0;
            if (mBurst && mBank == b) mBurst = 1'b0;
          end
        end
        3'b110: mBurst = 1'b0;
        default: ;
      endcase
    end
  endtask

  task automatic compare(string tag);
    bit bad;
    checks++;
    bad = (bankOpen !== mOpen) || (errPulse !== mErr) || (burstOn !== mBurst) ||
          (mBurst && burstBank !== mBank) ||
          (mOpen[0] && openRowA !== mRow[0]) || (mOpen[1] && openRowB !== mRow[1]);
    if (bad) begin
      errors++;
      $display("FAIL %s: got open=%b rowA=%h rowB=%h burst=%b/%b err=%b exp open=%b rowA=%h rowB=%h burst=%b/%b err=%b",
               tag, bankOpen, openRowA, openRowB, burstOn, burstBank, errPulse,
               mOpen, mRow[0], mRow[1], mBurst, mBank, mErr);
    end
  endtask

  // drive at falling edge, result sampled at the next falling edge
  task automatic issue(logic c, logic r, logic a, logic w, logic b, logic [ROW_W-1:0] ad);
    csN = c; rasN = r; casN = a; weN = w; bankAddr = b; addr = ad;
    @(negedge clk);
    modelStep(c, r, a, w, b, ad);
    compare(tagFor(c, r, a, w, ad));
  endtask

  task automatic act(logic b, logic [ROW_W-1:0] row); issue(0, 0, 1, 1, b, row); endtask
  task automatic rd(logic b);                          issue(0, 1, 0, 1, b, '0);  endtask
  task automatic wr(logic b);                          issue(0, 1, 0, 0, b, '0);  endtask
  task automatic pre(logic b, logic all);              issue(0, 0, 1, 0, b, all ? 11'h400 : 11'h0); endtask

  initial begin
    mOpen = 2'b00; mRow[0] = '0; mRow[1] = '0; mBurst = 1'b0; mBank = 1'b0; mErr = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    compare("R1 during reset");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // directed corner cases
    rd(1'b0);               // R4 access closed bank
    act(1'b0, 11'h123);     // R2 open bank A
    act(1'b0, 11'h055);     // R5 activate open bank, row kept
    rd(1'b0); rd(1'b0);     // R3 same row, no precharge
    act(1'b1, 11'h3AA);     // R2 open bank B
    rd(1'b0); wr(1'b1); rd(1'b0); wr(1'b1);   // R3 ping-pong every clock
    pre(1'b0, 1'b0);        // R8 other bank precharge keeps burst on B
    wr(1'b0);               // R4 write to now-closed bank A
    pre(1'b0, 1'b0);        // R6 precharge of closed bank, no error
    pre(1'b1, 1'b0);        // R8 precharge of bursting bank B
    act(1'b1, 11'h200);     // R2 row change after precharge
    rd(1'b1);
    issue(0, 1, 1, 0, 1'b0, '0);   // R9 burst stop
    issue(1, 0, 0, 0, 1'b1, '1);   // R10 deselect with junk
    issue(0, 0, 0, 1, 1'b0, '0);   // R10 refresh-like code ignored
    issue(0, 1, 1, 1, 1'b1, '0);   // R10 no-op
    act(1'b0, 11'h011); rd(1'b0);
    pre(1'b0, 1'b1);        // R7 precharge all

    // seeded random stream
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic b;
      logic [ROW_W-1:0] ad;
      op = int'($urandom % 16);
      b  = 1'($urandom);
      ad = ROW_W'($urandom);
      case (op)
        0, 1, 2:    act(b, ad);
        3, 4, 5:    rd(b);
        6, 7:       wr(b);
        8, 9:       pre(b, 1'b0);
        10:         pre(b, 1'b1);
        11:         issue(0, 1, 1, 0, b, ad);
        12:         issue(1, 1'($urandom), 1'($urandom), 1'($urandom), b, ad);
        13:         issue(0, 0, 0, 1'($urandom), b, ad);
        default:    issue(0, 1, 1, 1, b, ad);
      endcase
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule